// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Bank

This block is a bank of general-purpose pins behind a small word-addressed register bus. Each pin can drive an output or be sampled as an input. Every pin input passes through a synchronizer before any logic looks at it. Software sets the output value either by writing the whole word or by writing through set and clear aliases, which change only the bits written as 1. No read-modify-write is needed.

Each pin has four detect enables: level low, level high, rising edge and falling edge. Any mix of them may be on at the same time. When an enabled condition is met, the pin's sticky status bit is set.

The status word is combined with an interrupt-enable word to form one bank interrupt line. The enable word also has set and clear aliases. A separate wake request is raised only by edge detections, and only on pins chosen in a wake-enable word.

A two-state module controller handles clock gating:
- **MOD_RUN** is the reset state. A write to the control word with bit 0 = 1 takes the *gate* transition to **MOD_GATED**.
- In **MOD_GATED**, all detection is suppressed and status is frozen. A control write with bit 0 = 0 takes the *ungate* transition back to **MOD_RUN**.
- Any other control write leaves the state as it is.

Top module: `gpio_bank`

## Requirements
- R1: After reset, all pins are inputs (`pin_oe` = 0), the output data, all detect words, the status word, the interrupt-enable word and the wake-enable word are 0, `irq` and `wake` are 0, and the control word reads 0.
- R2: In the direction word (address 2), a 1 bit makes the pin an input with its `pin_oe` bit at 0. A 0 bit makes `pin_oe` 1 for that pin. `pin_out` always shows the output data word.
- R3: The output data word (address 3) has two aliases. A write to the set alias (address 4) sets the bits written as 1. A write to the clear alias (address 5) clears the bits written as 1. In both aliases, bits written as 0 keep their value.
- R4: Reading the data-in word (address 6) returns the pin values after the two-stage synchronizer, for every pin, whatever the pin's direction.
- R5: Each pin has four detect words: level low (address 7), level high (address 8), rising edge (address 9) and falling edge (address 10). They may be enabled in any combination, and a pin's event is the OR of all its enabled conditions. An edge is a difference between the synchronized value in the current cycle and in the previous cycle.
- R6: The status word (address 11) is sticky.
  - Writing 1 to a bit clears it.
  - Writing 0 to a bit has no effect.
  - A pin whose level condition still holds reads 1 again right after the clear, because a new event wins over a clear in the same cycle.
- R7: The interrupt-enable word (address 12) has a set alias (address 13) and a clear alias (address 14). Both change only the bits written as 1. `irq` is high exactly when some status bit and its enable bit are both 1.
- R8: `wake` pulses for one cycle after a cycle in which an enabled rising or falling edge was detected on a pin whose bit in the wake-enable word (address 15) is 1. Level detections never raise `wake`.
- R9: Writing 1 to bit 0 of the control word (address 1) gates the module. While gated, no status bit is set and no wake occurs. Writing 0 to bit 0 ungates the module. The control word reads back the gate state in bit 0.
- R10: The read-only revision word (address 0) returns the major version in bits 7:4 and the minor version in bits 3:0, which is 0x21 with the default parameters.
- R11: A bus access is one cycle with `bus_sel` high. `bus_wr` high means write. Read data appears on `bus_rdata` after the clock edge that captures the read and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Output data to the pads |
| pin_oe | output | 32 | Output enable per pin, 1 = drive |
| irq | output | 1 | Bank interrupt |
| wake | output | 1 | Wake request pulse |

## Verification
The hardest situation to reach is a controlled starting state for each detect mode. Level detections refill status as soon as it is cleared, and edges only count relative to the previous synchronized value.

The bench reaches that state by gating the module while it moves the pins to a pattern's start value, clearing status while still gated, and only then ungating and applying the final value. It sweeps all sixteen detect combinations across the pins at once, with the upper half of the bank driven inverted. This lets each of four start/end patterns cover every mode in both polarities. The expected status, wake count and interrupt level are computed per pin from the requirements.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_REV      = 4'd0,
        A_CTRL     = 4'd1,
        A_DIR      = 4'd2,
        A_DOUT     = 4'd3,
        A_DOUT_SET = 4'd4,
        A_DOUT_CLR = 4'd5,
        A_DIN      = 4'd6,
        A_DET_LO   = 4'd7,
        A_DET_HI   = 4'd8,
        A_DET_RISE = 4'd9,
        A_DET_FALL = 4'd10,
        A_STATUS   = 4'd11,
        A_IEN      = 4'd12,
        A_IEN_SET  = 4'd13,
        A_IEN_CLR  = 4'd14,
        A_WAKE_EN  = 4'd15
    } reg_addr_e;

    typedef enum logic {
        MOD_RUN   = 1'b0,
        MOD_GATED = 1'b1
    } mod_state_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] level,
    input  logic [W-1:0] det_lo,
    input  logic [W-1:0] det_hi,
    input  logic [W-1:0] det_rise,
    input  logic [W-1:0] det_fall,
    output logic [W-1:0] hit,
    output logic [W-1:0] edge_hit,
    output logic [W-1:0] prev
);

    logic [W-1:0] prev_q;
    logic [W-1:0] rise_w;
    logic [W-1:0] fall_w;
    logic [W-1:0] lvl_w;

    // History keeps running while gated so ungating never shows a stale edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    always_comb begin
        rise_w   = level & ~prev_q;
        fall_w   = ~level & prev_q;
        lvl_w    = (~level & det_lo) | (level & det_hi);
        edge_hit = en ? ((rise_w & det_rise) | (fall_w & det_fall)) : '0;
        hit      = edge_hit | (en ? lvl_w : '0);
    end

    assign prev = prev_q;

endmodule

// File: rtl/gpio_ctrl_fsm.sv
module gpio_ctrl_fsm
    import gpio_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic gate_req,
    output logic gated
);

    mod_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MOD_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MOD_RUN:   if (ctrl_wr && gate_req)  state_d = MOD_GATED;
            MOD_GATED: if (ctrl_wr && !gate_req) state_d = MOD_RUN;
        endcase
    end

    always_comb begin
        gated = (state_q == MOD_GATED);
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int         NPINS       = 32,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] REV_MAJOR   = 4'd2,
    parameter logic [3:0] REV_MINOR   = 4'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq,
    output logic              wake
);

    localparam int PAD_REV  = NPINS - 8;
    localparam int PAD_CTRL = NPINS - 1;

    reg_addr_e        addr_e;
    logic             wr_en, rd_en;
    logic [NPINS-1:0] dir_q, dout_q, ien_q, wake_en_q, status_q;
    logic [NPINS-1:0] det_lo_q, det_hi_q, det_rise_q, det_fall_q;
    logic [NPINS-1:0] pin_sync, pin_prev, hit, edge_hit;
    logic [NPINS-1:0] status_clr, rd_mux, rdata_q;
    logic             gated, wake_q;

    assign addr_e = reg_addr_e'(bus_addr);
    assign wr_en  = bus_sel & bus_wr;
    assign rd_en  = bus_sel & ~bus_wr;

    gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
    );

    gpio_detect #(.W(NPINS)) u_det (
        .clk(clk), .rst_n(rst_n), .en(~gated), .level(pin_sync),
        .det_lo(det_lo_q), .det_hi(det_hi_q),
        .det_rise(det_rise_q), .det_fall(det_fall_q),
        .hit(hit), .edge_hit(edge_hit), .prev(pin_prev)
    );

    gpio_ctrl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(wr_en && addr_e == A_CTRL),
        .gate_req(bus_wdata[0]),
        .gated(gated)
    );

    // Configuration words.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q      <= '1;
            dout_q     <= '0;
            ien_q      <= '0;
            wake_en_q  <= '0;
            det_lo_q   <= '0;
            det_hi_q   <= '0;
            det_rise_q <= '0;
            det_fall_q <= '0;
        end else if (wr_en) begin
            case (addr_e)
                A_DIR:      dir_q      <= bus_wdata;
                A_DOUT:     dout_q     <= bus_wdata;
                A_DOUT_SET: dout_q     <= dout_q | bus_wdata;
                A_DOUT_CLR: dout_q     <= dout_q & ~bus_wdata;
                A_DET_LO:   det_lo_q   <= bus_wdata;
                A_DET_HI:   det_hi_q   <= bus_wdata;
                A_DET_RISE: det_rise_q <= bus_wdata;
                A_DET_FALL: det_fall_q <= bus_wdata;
                A_IEN:      ien_q      <= bus_wdata;
                A_IEN_SET:  ien_q      <= ien_q | bus_wdata;
                A_IEN_CLR:  ien_q      <= ien_q & ~bus_wdata;
                A_WAKE_EN:  wake_en_q  <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Sticky status: a fresh event outranks a write-one-to-clear.
    assign status_clr = (wr_en && addr_e == A_STATUS) ? bus_wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            wake_q   <= 1'b0;
        end else begin
            status_q <= (status_q & ~status_clr) | hit;
            wake_q   <= |(edge_hit & wake_en_q);
        end
    end

    always_comb begin
        case (addr_e)
            A_REV:      rd_mux = {{PAD_REV{1'b0}}, REV_MAJOR, REV_MINOR};
            A_CTRL:     rd_mux = {{PAD_CTRL{1'b0}}, gated};
            A_DIR:      rd_mux = dir_q;
            A_DOUT:     rd_mux = dout_q;
            A_DIN:      rd_mux = pin_sync;
            A_DET_LO:   rd_mux = det_lo_q;
            A_DET_HI:   rd_mux = det_hi_q;
            A_DET_RISE: rd_mux = det_rise_q;
            A_DET_FALL: rd_mux = det_fall_q;
            A_STATUS:   rd_mux = status_q;
            A_IEN:      rd_mux = ien_q;
            A_WAKE_EN:  rd_mux = wake_en_q;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
    assign pin_out   = dout_q;
    assign pin_oe    = ~dir_q;
    assign irq       = |(status_q & ien_q);
    assign wake      = wake_q;

endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker #(
    parameter int NPINS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [3:0]       bus_addr,
    input logic [NPINS-1:0] bus_wdata,
    input logic             gated,
    input logic [NPINS-1:0] status_q,
    input logic [NPINS-1:0] dout_q,
    input logic [NPINS-1:0] ien_q,
    input logic [NPINS-1:0] edge_hit,
    input logic             wake
);

    logic wr_status, wr_dset, wr_dclr, wr_iset, wr_iclr;
    assign wr_status = bus_sel && bus_wr && bus_addr == 4'd11;
    assign wr_dset   = bus_sel && bus_wr && bus_addr == 4'd4;
    assign wr_dclr   = bus_sel && bus_wr && bus_addr == 4'd5;
    assign wr_iset   = bus_sel && bus_wr && bus_addr == 4'd13;
    assign wr_iclr   = bus_sel && bus_wr && bus_addr == 4'd14;

    assert_gated_no_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        gated |=> ((status_q & ~$past(status_q)) == '0));

    assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_status |=> ((~status_q & $past(status_q)) == '0));

    assert_dout_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dset |=> ((dout_q & $past(bus_wdata)) == $past(bus_wdata)));

    assert_dout_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dclr |=> ((dout_q & $past(bus_wdata)) == '0));

    assert_ien_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_iset |=> ((ien_q & $past(bus_wdata)) == $past(bus_wdata)));

    assert_ien_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_iclr |=> ((ien_q & $past(bus_wdata)) == '0));

    assert_wake_from_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> ($past(edge_hit) != '0));

endmodule

bind gpio_bank gpio_bank_checker #(.NPINS(NPINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .gated(gated),
    .status_q(status_q), .dout_q(dout_q), .ien_q(ien_q),
    .edge_hit(edge_hit), .wake(wake)
);

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
    import gpio_bank_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [31:0] pin_in = '0, pin_out, pin_oe;
    logic        irq, wake;

    int n_checks = 0, n_fail = 0, wake_cnt = 0;

    always #10 clk = ~clk;

    gpio_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq(irq), .wake(wake)
    );

    always @(negedge clk) if (rst_n && wake) wake_cnt++;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] rd, lo, hi, rise, fall, exp_st;
        int w0;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1: reset state
        check("R1 pin_oe", pin_oe, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 wake", {31'b0, wake}, 32'h0);
        bus_read(A_DIR, rd);    check("R1 dir", rd, 32'hFFFF_FFFF);
        bus_read(A_STATUS, rd); check("R1 status", rd, 32'h0);
        bus_read(A_CTRL, rd);   check("R1 ctrl", rd, 32'h0);

        // R10: revision
        bus_read(A_REV, rd); check("R10 revision", rd, 32'h21);

        // R5/R6/R7/R8: sweep of all detect combinations, upper half inverted
        lo = '0; hi = '0; rise = '0; fall = '0;
        for (int i = 0; i < 32; i++) begin
            int c = i % 16;
            lo[i] = c[0]; hi[i] = c[1]; rise[i] = c[2]; fall[i] = c[3];
        end
        bus_write(A_DET_LO, lo);
        bus_write(A_DET_HI, hi);
        bus_write(A_DET_RISE, rise);
        bus_write(A_DET_FALL, fall);
        bus_write(A_WAKE_EN, 32'h5555_5555);
        for (int p = 0; p < 4; p++) begin
            logic a, b, exp_w;
            logic [31:0] m;
            a = p[1]; b = p[0];
            exp_st = '0; exp_w = 1'b0;
            for (int i = 0; i < 32; i++) begin
                logic ai, bi;
                ai = (i < 16) ? a : ~a;
                bi = (i < 16) ? b : ~b;
                exp_st[i] = (lo[i] && (!ai || !bi)) || (hi[i] && (ai || bi)) ||
                            (rise[i] && !ai && bi) || (fall[i] && ai && !bi);
                if ((i % 2 == 0) && ((rise[i] && !ai && bi) || (fall[i] && ai && !bi)))
                    exp_w = 1'b1;
            end
            bus_write(A_CTRL, 32'h1);
            pin_in = {{16{~a}}, {16{a}}};
            idle(4);
            bus_write(A_STATUS, 32'hFFFF_FFFF);
            bus_write(A_CTRL, 32'h0);
            idle(4);
            w0 = wake_cnt;
            pin_in = {{16{~b}}, {16{b}}};
            idle(6);
            check($sformatf("R8 wake count pattern %0d", p), wake_cnt - w0, {31'b0, exp_w});
            bus_read(A_STATUS, rd);
            check($sformatf("R5 status pattern %0d", p), rd, exp_st);
            m = 32'h1111_1111 << p;
            bus_write(A_IEN, m);
            check($sformatf("R7 irq pattern %0d", p), {31'b0, irq}, {31'b0, |(exp_st & m)});
            bus_write(A_IEN, 32'h0);
        end

        // R6: level re-sets after clear, then clears once the level is gone
        bus_write(A_DET_LO, 32'h0);
        bus_write(A_DET_RISE, 32'h0);
        bus_write(A_DET_FALL, 32'h0);
        bus_write(A_DET_HI, 32'h8);
        pin_in = 32'h8;
        idle(4);
        bus_write(A_STATUS, 32'hFFFF_FFFF);
        bus_read(A_STATUS, rd); check("R6 level retrigger", rd, 32'h8);
        pin_in = 32'h0;
        idle(4);
        bus_write(A_STATUS, 32'hFFFF_FFFF);
        bus_read(A_STATUS, rd); check("R6 clear after level gone", rd, 32'h0);

        // R9: gating blocks detection and wake
        bus_write(A_DET_HI, 32'h0);
        bus_write(A_DET_RISE, 32'hFFFF_FFFF);
        bus_write(A_CTRL, 32'h1);
        bus_read(A_CTRL, rd); check("R9 ctrl readback", rd, 32'h1);
        w0 = wake_cnt;
        pin_in = 32'hFFFF_FFFF;
        idle(6);
        bus_read(A_STATUS, rd); check("R9 gated status", rd, 32'h0);
        check("R9 gated wake", wake_cnt - w0, 32'h0);
        bus_write(A_CTRL, 32'h0);
        pin_in = 32'h0;
        idle(4);
        pin_in = 32'hFFFF_FFFF;
        idle(6);
        bus_read(A_STATUS, rd); check("R9 ungated rise detect", rd, 32'hFFFF_FFFF);

        // R3: output aliases
        bus_write(A_DOUT, 32'hA5A5_00FF);
        bus_write(A_DOUT_SET, 32'h0F00_0000);
        bus_write(A_DOUT_CLR, 32'h0000_000F);
        bus_read(A_DOUT, rd); check("R3 dout aliases", rd, 32'hAFA5_00F0);
        check("R2 pin_out", pin_out, 32'hAFA5_00F0);

        // R2: direction
        bus_write(A_DIR, 32'h0000_FFFF);
        check("R2 pin_oe", pin_oe, 32'hFFFF_0000);

        // R4: data-in regardless of direction
        pin_in = 32'h1234_5678;
        idle(3);
        bus_read(A_DIN, rd); check("R4 data in", rd, 32'h1234_5678);

        // R7: enable aliases
        bus_write(A_IEN, 32'h0);
        bus_write(A_IEN_SET, 32'hF0F0_F0F0);
        bus_write(A_IEN_CLR, 32'h3000_0003);
        bus_read(A_IEN, rd); check("R7 ien aliases", rd, 32'hC0F0_F0F0);

        // R11: read data holds until the next read
        idle(3);
        check("R11 rdata hold", bus_rdata, 32'hC0F0_F0F0);

        finish_run();
    end

endmodule